// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block receives asynchronous serial characters of eight or nine data bits, least significant bit first, framed by a low start bit and a stop bit. The line is sampled on a 16x oversampling enable supplied from outside; each bit is resolved by a majority vote of three samples around mid-bit. A received character is delivered with its ninth bit and a one-cycle valid strobe. A stop bit sampled low raises a sticky framing-error flag.

A separate detector watches the line for a long continuous low level. Eleven bit times of low raise a sticky break flag. Optionally, the break also raises a one-cycle reset request, so that the chip can be steered into a boot or loader mode. Software sees the block through a two-register read/write port. A view-select bit in the status register decides whether the top bit of the control register is the frame-size mode bit or the framing-error flag.

The receive state machine has four states. RX_IDLE goes to RX_START on a low sample while enabled. RX_START goes to RX_DATA if the mid-bit vote is low, or back to RX_IDLE if it is high (a false start). RX_DATA goes to RX_STOP after the last data bit's vote. RX_STOP goes to RX_IDLE at the stop-bit vote, which delivers the character. Clearing the enable returns any state to RX_IDLE.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, both registers read 0x00, and rx_valid and brk_rst_req are low.
- R2: With receive enabled, a frame is shifted in LSB first. Control bit 7 (mode bit A) = 0 selects 8 data bits and = 1 selects 9. At the stop-bit vote, rx_data is updated and rx_valid pulses for one cycle.
- R3: rx_bit9 holds the ninth data bit in 9-bit frames. In 8-bit frames it holds the stop-bit value. Control bit 2 reads rx_bit9.
- R4: Each bit is the majority of the samples at oversampling counts 7, 8 and 9 after the start edge. A single low sample inside a high bit does not change the bit.
- R5: A start edge whose mid-bit vote is high is discarded without delivering a character. The next proper frame is received normally.
- R6: A stop bit voted low sets status bit 0 (framing error). The character is still delivered and RI is still set.
- R7: With status bit 3 (view select) = 1, control bit 7 reads the framing-error flag. With it = 0, control bit 7 reads mode bit A.
- R8: Mode bits A (control bit 7) and B (control bit 6) change on a control write only while view select is 0. While view select is 1, writing 0 to control bit 7 clears the framing-error flag.
- R9: The framing-error flag, the break flag (status bit 1) and RI (control bit 0) are sticky. They are cleared only by writing 0 to their bit. Writing 1 leaves them unchanged.
- R10: A break is declared after 176 consecutive low samples (11 bit times). It sets status bit 1. A shorter low period does not.
- R11: A break is reported once per continuous low period. The count restarts at every high sample.
- R12: When status bit 2 (break reset enable) is 1, a break pulses brk_rst_req for exactly one cycle. When it is 0, brk_rst_req stays low.
- R13: With control bit 4 (receive enable) = 0, the receiver delivers no characters.
- R14: Control bit 0 (RI) is set when a character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| rx_data | output | 8 | Last received character |
| rx_bit9 | output | 1 | Ninth bit or stop bit |
| rx_valid | output | 1 | One-cycle character strobe |
| brk_rst_req | output | 1 | One-cycle break reset request |

## Verification
The assertions check on every cycle that the valid strobe and the reset request last one cycle, that a reset request only appears while it is enabled, and that the sticky flags rise only after their causes and fall only after a register write. The bench scenarios show the parts no property can see: the values recovered from frames of both sizes, the rejection of false starts and of single-sample glitches, the 11-bit-time break threshold, and the two readings of control bit 7.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // control register field positions
    localparam int CTL_MDA = 7;
    localparam int CTL_MDB = 6;
    localparam int CTL_REN = 4;
    localparam int CTL_B9  = 2;
    localparam int CTL_RI  = 0;

    // status register field positions
    localparam int ST_FE    = 0;
    localparam int ST_BRK   = 1;
    localparam int ST_BRKEN = 2;
    localparam int ST_VIEW  = 3;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_ST  = 1'b1;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic line_s,
    output logic vote
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign line_s = sync_q[SYNC_STAGES-1];

    // two previous samples for the three-sample majority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hist_q <= 2'b11;
        else if (tick) hist_q <= {hist_q[0], line_s};
    end

    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_s) | (hist_q[0] & line_s);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_s,
    input  logic                 vote,
    input  logic                 ren,
    input  logic                 nine_bit,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] data,
    output logic                 bit9,
    output logic                 stop_bit
);
    localparam int CW      = $clog2(OVS);
    localparam int VOTE_AT = OVS / 2 + 1;
    localparam int IW      = $clog2(DATA_BITS + 1);

    rx_state_e            state_q, state_d;
    logic [CW-1:0]        cnt_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS:0]   sh_q;
    logic                 done_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 bit9_q, stop_q;
    logic                 mid;
    logic [IW-1:0]        last_idx;

    assign mid      = tick && (cnt_q == CW'(VOTE_AT));
    assign last_idx = nine_bit ? IW'(DATA_BITS) : IW'(DATA_BITS - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!ren) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (tick && !line_s) state_d = RX_START;
                RX_START: if (mid) state_d = vote ? RX_IDLE : RX_DATA;
                RX_DATA:  if (mid && idx_q == last_idx) state_d = RX_STOP;
                RX_STOP:  if (mid) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
            data_q <= '0;
            bit9_q <= 1'b0;
            stop_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (state_q == RX_IDLE) begin
                if (tick) cnt_q <= CW'(1);
            end else if (tick) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (ren && mid) begin
                unique case (state_q)
                    RX_START: idx_q <= '0;
                    RX_DATA: begin
                        sh_q  <= {vote, sh_q[DATA_BITS:1]};
                        idx_q <= idx_q + IW'(1);
                    end
                    RX_STOP: begin
                        done_q <= 1'b1;
                        stop_q <= vote;
                        data_q <= nine_bit ? sh_q[DATA_BITS-1:0] : sh_q[DATA_BITS:1];
                        bit9_q <= nine_bit ? sh_q[DATA_BITS] : vote;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frame_done = done_q;
    assign data       = data_q;
    assign bit9       = bit9_q;
    assign stop_bit   = stop_q;
endmodule

// File: rtl/uart_rx_brkdet.sv
module uart_rx_brkdet #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_s,
    output logic brk_pulse
);
    localparam int LIMIT = BRK_BITS * OVS;
    localparam int W     = $clog2(LIMIT + 1);

    logic [W-1:0] low_cnt_q;
    logic         seen_q;
    logic         pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            seen_q    <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (line_s) begin
                    low_cnt_q <= '0;
                    seen_q    <= 1'b0;
                end else if (!seen_q) begin
                    if (low_cnt_q == W'(LIMIT - 1)) begin
                        pulse_q   <= 1'b1;
                        seen_q    <= 1'b1;
                        low_cnt_q <= '0;
                    end else begin
                        low_cnt_q <= low_cnt_q + W'(1);
                    end
                end
            end
        end
    end

    assign brk_pulse = pulse_q;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       frame_done,
    input  logic       stop_bit,
    input  logic       bit9,
    input  logic       brk_pulse,
    output logic       mode_a,
    output logic       mode_b,
    output logic       ren,
    output logic       fe_flag,
    output logic       brk_flag,
    output logic       brk_en,
    output logic       view_sel,
    output logic       ri_flag,
    output logic       brk_rst_req
);
    logic wr_ctl, wr_st;
    logic fe_clr, brk_clr, ri_clr;
    logic fe_set;

    assign wr_ctl  = reg_we && (reg_addr == ADDR_CTL);
    assign wr_st   = reg_we && (reg_addr == ADDR_ST);
    assign fe_set  = frame_done && !stop_bit;
    assign fe_clr  = (wr_st && !reg_wdata[ST_FE]) ||
                     (wr_ctl && view_sel && !reg_wdata[CTL_MDA]);
    assign brk_clr = wr_st && !reg_wdata[ST_BRK];
    assign ri_clr  = wr_ctl && !reg_wdata[CTL_RI];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_a   <= 1'b0;
            mode_b   <= 1'b0;
            ren      <= 1'b0;
            fe_flag  <= 1'b0;
            brk_flag <= 1'b0;
            brk_en   <= 1'b0;
            view_sel <= 1'b0;
            ri_flag  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ren <= reg_wdata[CTL_REN];
                if (!view_sel) begin
                    mode_a <= reg_wdata[CTL_MDA];
                    mode_b <= reg_wdata[CTL_MDB];
                end
            end
            if (wr_st) begin
                brk_en   <= reg_wdata[ST_BRKEN];
                view_sel <= reg_wdata[ST_VIEW];
            end
            // set wins over a clear in the same cycle
            if (fe_set)      fe_flag <= 1'b1;
            else if (fe_clr) fe_flag <= 1'b0;
            if (brk_pulse)    brk_flag <= 1'b1;
            else if (brk_clr) brk_flag <= 1'b0;
            if (frame_done)  ri_flag <= 1'b1;
            else if (ri_clr) ri_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[CTL_MDA] = view_sel ? fe_flag : mode_a;
            reg_rdata[CTL_MDB] = mode_b;
            reg_rdata[CTL_REN] = ren;
            reg_rdata[CTL_B9]  = bit9;
            reg_rdata[CTL_RI]  = ri_flag;
        end else begin
            reg_rdata[ST_FE]    = fe_flag;
            reg_rdata[ST_BRK]   = brk_flag;
            reg_rdata[ST_BRKEN] = brk_en;
            reg_rdata[ST_VIEW]  = view_sel;
        end
    end

    assign brk_rst_req = brk_pulse && brk_en;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int BRK_BITS    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_valid,
    output logic       brk_rst_req
);
    logic line_s, vote;
    logic frame_done, stop_bit, bit9;
    logic brk_pulse;
    logic mode_a, mode_b, ren;
    logic fe_flag, brk_flag, brk_en, view_sel, ri_flag;

    uart_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .line_s(line_s), .vote(vote)
    );

    uart_rx_fsm #(.OVS(OVS), .DATA_BITS(8)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line_s(line_s), .vote(vote),
        .ren(ren), .nine_bit(mode_a), .frame_done(frame_done),
        .data(rx_data), .bit9(bit9), .stop_bit(stop_bit)
    );

    uart_rx_brkdet #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line_s(line_s),
        .brk_pulse(brk_pulse)
    );

    uart_rx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_done(frame_done), .stop_bit(stop_bit), .bit9(bit9),
        .brk_pulse(brk_pulse), .mode_a(mode_a), .mode_b(mode_b), .ren(ren),
        .fe_flag(fe_flag), .brk_flag(brk_flag), .brk_en(brk_en),
        .view_sel(view_sel), .ri_flag(ri_flag), .brk_rst_req(brk_rst_req)
    );

    assign rx_bit9  = bit9;
    assign rx_valid = frame_done;
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_we,
    input logic rx_valid,
    input logic brk_rst_req,
    input logic brk_pulse,
    input logic brk_en,
    input logic fe_flag,
    input logic brk_flag,
    input logic ri_flag
);
    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r12_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        brk_rst_req |=> !brk_rst_req);

    a_r12_req_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        brk_rst_req |-> brk_en && brk_pulse);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    a_r10_brk_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(brk_pulse));

    a_r6_fe_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_flag) |-> $past(rx_valid));

    a_r14_ri_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri_flag) |-> $past(rx_valid));

    a_r9_fe_fall_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_flag) |-> $past(reg_we));

    a_r9_brk_fall_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flag) |-> $past(reg_we));
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .rx_valid(rx_valid),
    .brk_rst_req(brk_rst_req), .brk_pulse(brk_pulse), .brk_en(brk_en),
    .fe_flag(fe_flag), .brk_flag(brk_flag), .ri_flag(ri_flag)
);

// File: tb/uart_rx_brk_bench.sv
module uart_rx_brk_bench;
    localparam int BIT = 32; // tick every 2 clocks, 16 ticks per bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic rxd = 1'b1;
    logic reg_we = 1'b0;
    logic reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata, rx_data;
    logic rx_bit9, rx_valid, brk_rst_req;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_req = 0;
    logic [7:0] cap_data;
    logic cap_b9;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) tick16 <= ~tick16;

    uart_rx_brk u_uart_rx_brk (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_valid(rx_valid), .brk_rst_req(brk_rst_req)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            n_valid  <= n_valid + 1;
            cap_data <= rx_data;
            cap_b9   <= rx_bit9;
        end
        if (brk_rst_req) n_req <= n_req + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic hold(input logic v, input int bits);
        @(negedge clk);
        rxd = v;
        repeat (bits * BIT) @(negedge clk);
    endtask

    // glitch_bit >= 0 puts a one-sample low pulse in the middle of that data bit
    task automatic send(input logic [8:0] d, input logic nine, input logic stp,
                        input int glitch_bit);
        int nb = nine ? 9 : 8;
        hold(1'b0, 1);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rxd = d[i];
            for (int c = 1; c < BIT; c++) begin
                @(negedge clk);
                if (i == glitch_bit) rxd = (c == 16 || c == 17) ? 1'b0 : d[i];
            end
        end
        hold(stp, 1);
        hold(1'b1, 2);
    endtask

    // expected ninth-bit value from the frame definition
    function automatic logic exp_b9(input logic [8:0] d, input logic nine, input logic stp);
        return nine ? d[8] : stp;
    endfunction

    initial begin
        logic [7:0] r;
        int v0;
        #1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, r); check("R1 ctl reset", r, 8'h00);
        rd(1'b1, r); check("R1 status reset", r, 8'h00);
        check("R1 valid reset", rx_valid, 0);
        check("R1 req reset", brk_rst_req, 0);

        // R2 R3 R14: 8-bit frame
        wr(1'b0, 8'h10);
        send(9'h0A5, 1'b0, 1'b1, -1);
        check("R2 8-bit count", n_valid, 1);
        check("R2 8-bit data", cap_data, 8'hA5);
        check("R3 8-bit ninth=stop", cap_b9, 1);
        rd(1'b0, r); check("R14 RI set", r[0], 1);
        check("R3 ctl bit2", r[2], 1);
        wr(1'b0, 8'h11);
        rd(1'b0, r); check("R9 RI write 1 keeps", r[0], 1);
        wr(1'b0, 8'h10);
        rd(1'b0, r); check("R9 RI cleared", r[0], 0);

        // 9-bit frames
        wr(1'b0, 8'h90);
        send(9'h13C, 1'b1, 1'b1, -1);
        check("R2 9-bit data", cap_data, 8'h3C);
        check("R3 9-bit ninth=1", cap_b9, 1);
        send(9'h0C3, 1'b1, 1'b1, -1);
        check("R3 9-bit ninth=0", cap_b9, 0);

        // R5 false start
        v0 = n_valid;
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        hold(1'b1, 3);
        check("R5 false start dropped", n_valid, v0);
        send(9'h15A, 1'b1, 1'b1, -1);
        check("R5 next frame", cap_data, 8'h5A);

        // R4 glitch inside a high bit
        send(9'h1FF, 1'b1, 1'b1, 3);
        check("R4 glitch masked", cap_data, 8'hFF);

        // R6 framing error, R9 stickiness
        wr(1'b0, 8'h10);
        v0 = n_valid;
        send(9'h055, 1'b0, 1'b0, -1);
        check("R6 frame delivered", n_valid, v0 + 1);
        rd(1'b1, r); check("R6 FE set", r[0], 1);
        rd(1'b0, r); check("R6 RI set", r[0], 1);
        wr(1'b1, 8'h01);
        rd(1'b1, r); check("R9 FE write 1 keeps", r[0], 1);
        wr(1'b1, 8'h00);
        rd(1'b1, r); check("R9 FE cleared", r[0], 0);

        // R7 R8 view select
        wr(1'b0, 8'h90);
        wr(1'b1, 8'h08);
        rd(1'b0, r); check("R7 view shows FE=0", r[7], 0);
        send(9'h001, 1'b1, 1'b0, -1);
        rd(1'b0, r); check("R7 view shows FE=1", r[7], 1);
        wr(1'b0, 8'h50);
        rd(1'b1, r); check("R8 ctl bit7 clears FE", r[0], 0);
        wr(1'b1, 8'h00);
        rd(1'b0, r); check("R8 modes unchanged", r[7:6], 2'b10);
        check("R7 view off shows mode", r[7], 1);

        // R13 receive disabled
        wr(1'b0, 8'h00);
        v0 = n_valid;
        send(9'h0AA, 1'b0, 1'b1, -1);
        check("R13 disabled ignores", n_valid, v0);

        // R10 R11 R12 break
        wr(1'b1, 8'h04);
        hold(1'b0, 10); hold(1'b1, 1);
        rd(1'b1, r); check("R10 short low no break", r[1], 0);
        check("R12 no req short", n_req, 0);
        hold(1'b0, 30); hold(1'b1, 1);
        rd(1'b1, r); check("R10 break flag", r[1], 1);
        check("R11 R12 one req cycle", n_req, 1);
        wr(1'b1, 8'h06);
        rd(1'b1, r); check("R9 BRK write 1 keeps", r[1], 1);
        wr(1'b1, 8'h00);
        rd(1'b1, r); check("R9 BRK cleared", r[1], 0);
        hold(1'b0, 12); hold(1'b1, 1);
        rd(1'b1, r); check("R11 second period detected", r[1], 1);
        check("R12 disabled no req", n_req, 1);
        wr(1'b1, 8'h00);

        // random frames
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 20; k++) begin
            logic [8:0] d = 9'($urandom);
            logic nine = 1'($urandom);
            logic stp = ((d[7:0] != 0) && ($urandom % 5 == 0)) ? 1'b0 : 1'b1;
            v0 = n_valid;
            wr(1'b0, {nine, 7'h10});
            send(d, nine, stp, -1);
            check("R2 rand count", n_valid, v0 + 1);
            check("R2 rand data", cap_data, nine ? d[7:0] : d[7:0]);
            check("R3 rand ninth", cap_b9, exp_b9(d, nine, stp));
            rd(1'b1, r); check("R6 rand FE", r[0], !stp);
            wr(1'b1, 8'h00);
            wr(1'b0, 8'h10);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule